// File: doc/BRIEF.md
# Circular delay-buffer address mapper

This block sits between an effects processor and its shared sample RAM. The processor addresses delay lines by a small map number and a 16-bit logical offset. The block turns that pair into a physical RAM address, so each delay line occupies its own circular region and wraps inside it.

Eight map registers each hold three fields. A 3-bit size code selects a region length that is a power of two, from 1 K to 128 K samples. An 8-bit base code places the region on any 1 K boundary. A 5-bit control field is kept but plays no part in address generation.

A shared rotation pointer steps down by one on every sample-period strobe, so every region turns by one sample per period. The offset plus the pointer is masked to the region length and then added to the region base. The result wraps within the 256 K-sample RAM and comes out of a register one cycle after the request.

Top module: `dlbuf_addr_map`

## Requirements
- R1: After reset, `rsp_valid` is 0, `rsp_addr` is 0, every map register reads back 0 and the rotation pointer is 0.
- R2: When `cfg_we` is high at a clock edge, `cfg_wdata` is stored in map register `cfg_idx`. `cfg_rdata` always shows map register `cfg_idx` combinationally, so a write is visible from the cycle after the edge.
- R3: The map register layout is as follows. Bits 7:0 are the base code o, bits 10:8 are the size code s, and bits 15:11 are the control field. All 16 bits are stored and read back unchanged.
- R4: A region is 1 << (10 + s) samples long, so every address it produces lies in [base, base + length) modulo 2^18.
- R5: The region base is o << 10. It does not have to be aligned to the region length. The final sum wraps modulo 2^18; for example, base 0x3FC00 with 128 K length and masked offset 0xFFFF gives 0x0FBFF.
- R6: The response address is (base + ((offset + pointer) mod length)) mod 2^18, with the 16-bit offset zero-extended.
- R7: Each cycle with `tick` high lowers the pointer by 1, and 0 wraps to 0x3FFFF. A request in the same cycle as `tick` uses the pointer value from before the decrement.
- R8: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high, and `rsp_addr` is updated then. Without a request, `rsp_addr` holds its value.
- R9: The control field has no effect on the address. Two maps that differ only in bits 15:11 give equal addresses for equal offsets.
- R10: When a request and a write to the same map share a clock edge, the request uses the map contents from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Map register write enable |
| cfg_idx | input | 3 | Map register select for write and readback |
| cfg_wdata | input | 16 | Map register write data |
| cfg_rdata | output | 16 | Contents of map register `cfg_idx` |
| tick | input | 1 | Sample-period strobe; steps the rotation pointer |
| req_valid | input | 1 | Address request |
| req_map | input | 3 | Map register used by the request |
| req_ofs | input | 16 | Logical offset of the request |
| rsp_valid | output | 1 | Response address valid |
| rsp_addr | output | 18 | Physical RAM address |

## Verification
The bench builds the block with its default parameters: eight maps, 1 K grain, 8-bit base code and 16-bit offsets, which give an 18-bit address. With these values, the largest base code plus the largest region length runs past the top of the RAM, so the wrap of the final sum can be reached. The pointer wraps to 0x3FFFF at the very first strobe after reset, so the pointer wrap is reached as well. A later random phase mixes strobes, requests and map writes in the same cycles, which exercises the ordering rules at every region size.

// File: rtl/dlbuf_addr_map.sv
module dlbuf_addr_map #(
  parameter int NUM_MAPS   = 8,
  parameter int SIZE_W     = 3,
  parameter int BASE_W     = 8,
  parameter int CTL_W      = 5,
  parameter int GRAIN_LOG2 = 10,
  parameter int OFS_W      = 16,
  parameter int IDX_W      = $clog2(NUM_MAPS),
  parameter int MAP_W      = CTL_W + SIZE_W + BASE_W,
  parameter int ADDR_W     = BASE_W + GRAIN_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [MAP_W-1:0]  cfg_wdata,
  output logic [MAP_W-1:0]  cfg_rdata,
  input  logic              tick,
  input  logic              req_valid,
  input  logic [IDX_W-1:0]  req_map,
  input  logic [OFS_W-1:0]  req_ofs,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] rsp_addr
);

  logic [MAP_W-1:0]  map_q [NUM_MAPS];
  logic [ADDR_W-1:0] ptr_q;

  for (genvar i = 0; i < NUM_MAPS; i++) begin : g_map
    always_ff @(posedge clk) begin
      if (!rst_n)                                    map_q[i] <= '0;
      else if (cfg_we && cfg_idx == IDX_W'(i))      map_q[i] <= cfg_wdata;
    end
  end

  assign cfg_rdata = map_q[cfg_idx];

  logic [MAP_W-1:0]  sel;
  logic [SIZE_W-1:0] size_code;
  logic [ADDR_W-1:0] base, mask, ofs_ext, addr_next;

  assign sel       = map_q[req_map];
  assign size_code = sel[BASE_W +: SIZE_W];
  assign base      = {sel[BASE_W-1:0], {GRAIN_LOG2{1'b0}}};
  assign mask      = ~({ADDR_W{1'b1}} << (GRAIN_LOG2 + int'(size_code)));
  assign ofs_ext   = {{(ADDR_W-OFS_W){1'b0}}, req_ofs};
  assign addr_next = base + ((ofs_ext + ptr_q) & mask);

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= '0;
    else if (tick) ptr_q <= ptr_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) rsp_addr <= addr_next;
    end
  end

  // R2
  map_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> map_q[$past(cfg_idx)] == $past(cfg_wdata));

  // R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ptr_q == $past(ptr_q) - 1'b1);

  // R7
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(ptr_q));

  // R8
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R8
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid && $stable(rsp_addr));

  // R4
  in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ((rsp_addr - $past(base)) & ~$past(mask)) == '0);

endmodule

// File: tb/dlbuf_addr_map_tb.sv
module dlbuf_addr_map_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_idx = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] cfg_rdata;
  logic        tick = 0;
  logic        req_valid = 0;
  logic [2:0]  req_map = 0;
  logic [15:0] req_ofs = 0;
  logic        rsp_valid;
  logic [17:0] rsp_addr;

  always #5 clk = ~clk;

  dlbuf_addr_map u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .tick(tick),
    .req_valid(req_valid), .req_map(req_map), .req_ofs(req_ofs),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr));

  int    checks = 0, errors = 0;
  bit    done = 0;
  string cur_tag = "R1";

  int m_maps [8];
  int m_ptr;
  int exp_valid, exp_addr;

  function automatic int model_addr(int mv, int ofs, int p);
    int len, base;
    len  = 1 << (10 + ((mv >> 8) & 7));
    base = (mv & 255) * 1024;
    return (base + ((ofs + p) % len)) % 262144;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) m_maps[i] <= 0;
      m_ptr <= 0; exp_valid <= 0; exp_addr <= 0;
    end else begin
      exp_valid <= int'(req_valid);
      if (req_valid) exp_addr <= model_addr(m_maps[req_map], int'(req_ofs), m_ptr);
      if (tick) m_ptr <= (m_ptr + 262143) % 262144;
      if (cfg_we) m_maps[cfg_idx] <= int'(cfg_wdata);
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check({cur_tag, " R8 valid"}, int'(rsp_valid), exp_valid);
    check({cur_tag, " R6 addr"}, int'(rsp_addr), exp_addr);
  end

  task automatic wr(int idx, int val);
    @(negedge clk); cfg_we = 1; cfg_idx = 3'(idx); cfg_wdata = 16'(val);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic rd(string tag, int idx, int exp);
    cfg_idx = 3'(idx); #1;
    check(tag, int'(cfg_rdata), exp);
  endtask

  task automatic req(int mp, int ofs, bit tk);
    @(negedge clk); req_valid = 1; req_map = 3'(mp); req_ofs = 16'(ofs); tick = tk;
    @(negedge clk); req_valid = 0; tick = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 rsp_valid", int'(rsp_valid), 0);
    check("R1 rsp_addr", int'(rsp_addr), 0);
    for (int i = 0; i < 8; i++) rd("R1 map reset", i, 0);

    cur_tag = "R2";
    wr(0, 16'h0000);
    wr(1, 16'h06A0);
    wr(2, 16'h07FF);
    wr(3, 16'hFEA0);
    wr(4, 16'h0310);
    wr(5, 16'hABCD);
    rd("R2 readback map1", 1, 16'h06A0);
    rd("R3 all bits map3", 3, 16'hFEA0);
    rd("R3 all bits map5", 5, 16'hABCD);

    cur_tag = "R6";
    req(1, 16'h1234, 0);
    check("R6 unaligned base", int'(rsp_addr), 18'h29234);
    req(0, 16'hFFFF, 0);
    check("R4 1K mask", int'(rsp_addr), 16'h03FF);
    req(2, 16'hFFFF, 0);
    check("R5 sum wraps", int'(rsp_addr), 18'h0FBFF);
    req(4, 16'h2345, 0);
    check("R4 8K region", int'(rsp_addr), 18'h04000 + 16'h0345);

    cur_tag = "R7";
    req(0, 0, 1);
    check("R7 request with tick sees old ptr", int'(rsp_addr), 0);
    req(0, 0, 0);
    check("R7 ptr wraps to 3FFFF", int'(rsp_addr), 16'h03FF);
    req(2, 1, 0);
    check("R7 ptr plus offset", int'(rsp_addr), 18'h3FC00);

    cur_tag = "R8";
    repeat (4) @(negedge clk);
    check("R8 idle valid low", int'(rsp_valid), 0);
    check("R8 addr held", int'(rsp_addr), 18'h3FC00);

    cur_tag = "R9";
    req(1, 16'h7777, 0);
    begin
      int a1;
      a1 = int'(rsp_addr);
      req(3, 16'h7777, 0);
      check("R9 control field ignored", int'(rsp_addr), a1);
    end

    cur_tag = "R10";
    @(negedge clk);
    cfg_we = 1; cfg_idx = 1; cfg_wdata = 16'h0050;
    req_valid = 1; req_map = 1; req_ofs = 16'h0010;
    @(negedge clk);
    cfg_we = 0; req_valid = 0;
    check("R10 old map used", int'(rsp_addr), model_addr(16'h06A0, 16'h0010, 262143));
    rd("R10 new map stored", 1, 16'h0050);

    cur_tag = "R6 random";
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      tick      = ($urandom % 3) == 0;
      req_valid = ($urandom % 4) != 0;
      req_map   = 3'($urandom);
      req_ofs   = 16'($urandom);
      cfg_we    = ($urandom % 16) == 0;
      cfg_idx   = 3'($urandom);
      cfg_wdata = 16'($urandom);
    end
    @(negedge clk);
    tick = 0; req_valid = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule